// File: doc/BRIEF.md
# Overtemperature Alert Controller

This block watches a stream of signed temperature results from a converter and drives one alert pin. Each result is checked against two programmable 16-bit limits: a trip limit and a lower release limit. A result counts as a fault when it is at or above the trip limit. The alert trips only after a chosen number of consecutive faults. Software sets the block up through a control byte and the two limit registers. The control byte selects comparator or latched-interrupt behaviour, pin polarity, fault-run length, shutdown, single-conversion operation and bus-alert signalling.

The block also contains a conversion scheduler. In continuous operation it asks the converter for a new result once per programmable period. The default period is 100 ms at the design clock. In single-conversion operation it asks only when a trigger value is written to the pointer port. In shutdown it makes no requests. The serial bus and the converter itself sit outside the block.

The result input is a valid-only stream. The block accepts every result on the cycle it is offered and never applies back-pressure, so the input has no ready signal. Control and status pins are plain levels or single-cycle strobes.

Top module: `ota_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, the trip limit (address 1) reads 0x5000, the release limit (address 2) reads 0x4B00, `alert_o` is 1 and `conv_req` is 0.
- R2: Writes to address 1 or 2 store bits 15:4, and bits 3:0 read back as zero. Writes to address 0 store the low byte with bit 6 forced to zero. Address 3 reads zero.
- R3: Control bits 4:3 set the fault-run length: code 0 needs 1 fault, code 1 needs 2, code 2 needs 4 and code 3 needs 6. A fault is a result that is at or above the trip limit in signed comparison. Any result below the trip limit restarts the run.
- R4: When control bit 1 is 0 (comparator mode), the internal alarm sets once the run length is reached. It clears only on a result strictly below the release limit. `rd_ack` has no effect in this mode.
- R5: When control bit 1 is 1 (interrupt mode), the alarm latches once the run length is reached and holds until `rd_ack`. It cannot latch again until a result strictly below the release limit has been seen after the clear.
- R6: Control bit 2 sets pin polarity. With 0, `alert_o` is low while the alarm is set. With 1, `alert_o` is high while the alarm is set.
- R7: When interrupt mode and control bit 7 are both set, the pin is active low whatever bit 2 holds. In comparator mode bit 7 has no effect.
- R8: When bits 0 and 5 of the control byte are both 0, `conv_req` pulses for one cycle every `PERIOD_CYC` cycles. The first pulse comes `PERIOD_CYC` cycles after the block leaves shutdown.
- R9: While control bit 0 (shutdown) is 1, `conv_req` stays 0. Clearing the bit restarts the periodic requests.
- R10: While control bit 5 (single conversion) is 1, `conv_req` pulses exactly once, on the cycle after a pointer write of 0x04. Other pointer values produce no request.
- R11: Any write to the control byte clears the fault run and the alarm state, and re-arms interrupt mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 trip limit, 2 release limit |
| reg_wdata | input | 16 | Register write data; the control byte is in bits 7:0 |
| reg_rdata | output | 16 | Combinational read of the addressed register, upper byte in 15:8 |
| ptr_wr_en | input | 1 | Pointer write strobe |
| ptr_wdata | input | 8 | Pointer value |
| res_valid | input | 1 | Converter result valid, always accepted |
| res_data | input | 16 | Signed converter result |
| rd_ack | input | 1 | Read acknowledge that clears the latched interrupt |
| conv_req | output | 1 | Single-cycle conversion request |
| alert_o | output | 1 | Alert pin after polarity |

## Verification
A result offered in cycle N updates the alarm register at the next edge, so `alert_o` carries its effect from cycle N+1 on. A register write and an `rd_ack` behave the same way. The bench drives each stimulus for one cycle at a falling edge and samples at the following falling edge, exactly one register stage later. Conversion requests are registered, so a trigger pointer write shows on `conv_req` one cycle later. The bench measures periodic requests by counting falling edges between pulses, which must equal the period.

// File: rtl/ota_pkg.sv
package ota_pkg;
  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_HOT = 2'd1;
  localparam logic [1:0] ADDR_HYS = 2'd2;
  localparam int         RUN_W    = 3;

  // fault-run length for a queue code: 1, 2, 4, 6
  function automatic logic [RUN_W-1:0] run_need(input logic [1:0] code);
    run_need = (code == 2'd0) ? RUN_W'(1) : RUN_W'({code, 1'b0});
  endfunction
endpackage

// File: rtl/ota_regs.sv
module ota_regs
  import ota_pkg::*;
#(
  parameter int          TW      = 16,
  parameter int          PAD     = 4,
  parameter logic [TW-1:0] HOT_RST = 16'h5000,
  parameter logic [TW-1:0] HYS_RST = 16'h4B00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] rdata,
  output logic          ctl_wr,
  output logic          sd,
  output logic          intr,
  output logic          pol,
  output logic [1:0]    fq,
  output logic          oneshot,
  output logic          smb,
  output logic [TW-1:0] lim_hot,
  output logic [TW-1:0] lim_hys
);
  localparam logic [TW-1:0] LIM_MASK = {{(TW-PAD){1'b1}}, {PAD{1'b0}}};
  localparam logic [7:0]    CTL_MASK = 8'hBF;

  logic [7:0]    ctl_q;
  logic [TW-1:0] hot_q, hys_q;
  logic [TW-1:0] wmix;

  assign wmix = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      hot_q <= HOT_RST;
      hys_q <= HYS_RST;
    end else if (wr_en) begin
      unique case (addr)
        ADDR_CTL: ctl_q <= wmix[7:0] & CTL_MASK;
        ADDR_HOT: hot_q <= wmix & LIM_MASK;
        ADDR_HYS: hys_q <= wmix & LIM_MASK;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CTL: rdata = {{(TW-8){1'b0}}, ctl_q};
      ADDR_HOT: rdata = hot_q;
      ADDR_HYS: rdata = hys_q;
      default:  rdata = '0;
    endcase
  end

  assign ctl_wr  = wr_en && (addr == ADDR_CTL);
  assign sd      = ctl_q[0];
  assign intr    = ctl_q[1];
  assign pol     = ctl_q[2];
  assign fq      = ctl_q[4:3];
  assign oneshot = ctl_q[5];
  assign smb     = ctl_q[7];
  assign lim_hot = hot_q;
  assign lim_hys = hys_q;

  a_r2_lim_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_HOT) |=> (hot_q == ($past(wdata) & LIM_MASK)));
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_CTL) |=> (ctl_q[6] == 1'b0));
endmodule

// File: rtl/ota_sched.sv
module ota_sched #(
  parameter int         PERIOD_CYC = 25_000_000,
  parameter logic [7:0] TRIG       = 8'h04,
  localparam int        CW         = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sd,
  input  logic       oneshot,
  input  logic       ptr_wr,
  input  logic [7:0] ptr_data,
  output logic       req
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          req_q;
  logic          trig;

  assign trig = ptr_wr && (ptr_data == TRIG) && !req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (sd) begin
        cnt_q <= '0;
      end else if (oneshot) begin
        cnt_q <= '0;
        if (trig) req_q <= 1'b1;
      end else if (cnt_q == LAST) begin
        cnt_q <= '0;
        req_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign req = req_q;

  a_r9_quiet_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    sd |=> !req_q);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  a_r10_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot && !sd && !(ptr_wr && ptr_data == TRIG)) |=> !req_q);
endmodule

// File: rtl/ota_alarm.sv
module ota_alarm
  import ota_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          intr,
  input  logic [1:0]    fq,
  input  logic          res_valid,
  input  logic [TW-1:0] res_data,
  input  logic [TW-1:0] lim_hot,
  input  logic [TW-1:0] lim_hys,
  input  logic          rd_ack,
  output logic          alarm
);
  logic [RUN_W-1:0] run_q, run_nx;
  logic             cmp_q, lat_q, arm_q;
  logic             hot, cold, hit;

  assign hot    = $signed(res_data) >= $signed(lim_hot);
  assign cold   = $signed(res_data) <  $signed(lim_hys);
  assign run_nx = !hot ? '0 : ((&run_q) ? run_q : run_q + 1'b1);
  assign hit    = res_valid && hot && (run_nx >= run_need(fq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      cmp_q <= 1'b0;
      lat_q <= 1'b0;
      arm_q <= 1'b1;
    end else if (clr) begin
      run_q <= '0;
      cmp_q <= 1'b0;
      lat_q <= 1'b0;
      arm_q <= 1'b1;
    end else begin
      if (res_valid) run_q <= run_nx;
      // comparator path
      if (hit)                    cmp_q <= 1'b1;
      else if (res_valid && cold) cmp_q <= 1'b0;
      // interrupt path
      if (intr) begin
        if (arm_q && hit) begin
          lat_q <= 1'b1;
          arm_q <= 1'b0;
        end else begin
          if (rd_ack) lat_q <= 1'b0;
          if (!arm_q && !lat_q && res_valid && cold) arm_q <= 1'b1;
        end
      end
    end
  end

  assign alarm = intr ? lat_q : cmp_q;

  a_r3_run_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !hot) |=> (run_q == '0));
  a_r4_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q && !clr && !(res_valid && cold)) |=> cmp_q);
  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (intr && lat_q && !rd_ack && !clr) |=> lat_q);
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!lat_q && !cmp_q && arm_q));
endmodule

// File: rtl/ota_ctrl.sv
module ota_ctrl #(
  parameter int          TW         = 16,
  parameter int          PAD        = 4,
  parameter int          PERIOD_CYC = 25_000_000,
  parameter logic [TW-1:0] HOT_RST  = 16'h5000,
  parameter logic [TW-1:0] HYS_RST  = 16'h4B00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_addr,
  input  logic [TW-1:0] reg_wdata,
  output logic [TW-1:0] reg_rdata,
  input  logic          ptr_wr_en,
  input  logic [7:0]    ptr_wdata,
  input  logic          res_valid,
  input  logic [TW-1:0] res_data,
  input  logic          rd_ack,
  output logic          conv_req,
  output logic          alert_o
);
  logic          ctl_wr, sd, intr, pol, oneshot, smb;
  logic [1:0]    fq;
  logic [TW-1:0] lim_hot, lim_hys;
  logic          alarm, act_low;

  ota_regs #(.TW(TW), .PAD(PAD), .HOT_RST(HOT_RST), .HYS_RST(HYS_RST)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctl_wr(ctl_wr), .sd(sd),
    .intr(intr), .pol(pol), .fq(fq), .oneshot(oneshot), .smb(smb),
    .lim_hot(lim_hot), .lim_hys(lim_hys)
  );

  ota_sched #(.PERIOD_CYC(PERIOD_CYC)) sched_i (
    .clk(clk), .rst_n(rst_n), .sd(sd), .oneshot(oneshot),
    .ptr_wr(ptr_wr_en), .ptr_data(ptr_wdata), .req(conv_req)
  );

  ota_alarm #(.TW(TW)) alarm_i (
    .clk(clk), .rst_n(rst_n), .clr(ctl_wr), .intr(intr), .fq(fq),
    .res_valid(res_valid), .res_data(res_data), .lim_hot(lim_hot),
    .lim_hys(lim_hys), .rd_ack(rd_ack), .alarm(alarm)
  );

  // bus-alert signalling in interrupt mode is always active low
  assign act_low = (intr && smb) ? 1'b1 : !pol;
  assign alert_o = alarm ^ act_low;

  a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm && !intr) |-> (alert_o == !pol));
  a_r7_smb_low: assert property (@(posedge clk) disable iff (!rst_n)
    (intr && smb) |-> (alert_o == !alarm));
endmodule

// File: tb/ota_ctrl_tb.sv
module ota_ctrl_tb_top;
  localparam int P  = 16;
  localparam int NP = 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ptr_wr_en = 1'b0;
  logic [7:0]  ptr_wdata = '0;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic        rd_ack = 1'b0;
  logic        conv_req, alert_o;

  int checks = 0, fails = 0, pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ota_ctrl #(.PERIOD_CYC(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ptr_wr_en(ptr_wr_en),
    .ptr_wdata(ptr_wdata), .res_valid(res_valid), .res_data(res_data),
    .rd_ack(rd_ack), .conv_req(conv_req), .alert_o(alert_o)
  );

  always @(negedge clk) if (conv_req) pulses++;

  // pattern: bit 16 = acknowledge step, else bits 15:0 = result
  logic [16:0] pat [NP];
  initial begin
    pat = '{17'h00100, 17'h07FF0, 17'h00100, 17'h00100, 17'h00100, 17'h00100,
            17'h00100, 17'h00000, 17'h0FF00, 17'h10000, 17'h07FF0, 17'h07FF0,
            17'h0FE00, 17'h10000, 17'h00100, 17'h00100, 17'h00100, 17'h00100,
            17'h00100, 17'h08000, 17'h00100, 17'h00100};
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  // bench-side alarm model
  int  m_run, m_need; bit m_cmp, m_lat, m_arm;
  bit  m_intr, m_pol, m_smb;

  function automatic bit exp_pin();
    bit on = m_intr ? m_lat : m_cmp;
    bit low = (m_intr && m_smb) || !m_pol;
    return low ? !on : on;
  endfunction

  task automatic step(input logic [16:0] s, input string tag);
    if (s[16]) begin
      @(negedge clk); rd_ack = 1'b1;
      @(negedge clk); rd_ack = 1'b0;
      if (m_intr) m_lat = 1'b0;
    end else begin
      int t = $signed(s[15:0]);
      bit hit;
      @(negedge clk); res_valid = 1'b1; res_data = s[15:0];
      @(negedge clk); res_valid = 1'b0;
      m_run = (t >= 256) ? ((m_run < 6) ? m_run + 1 : 6) : 0;
      hit = (m_run >= m_need);
      if (hit) m_cmp = 1'b1; else if (t < -256) m_cmp = 1'b0;
      if (m_intr) begin
        if (m_arm && hit) begin m_lat = 1'b1; m_arm = 1'b0; end
        else if (!m_arm && !m_lat && t < -256) m_arm = 1'b1;
      end
    end
    chk(tag, alert_o, exp_pin());
  endtask

  logic [15:0] rv;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, rv); chk("R1 ctl", rv, 16'h0000);
    rd(2'd1, rv); chk("R1 trip", rv, 16'h5000);
    rd(2'd2, rv); chk("R1 release", rv, 16'h4B00);
    chk("R1 alert", alert_o, 1'b1);
    chk("R1 req", conv_req, 1'b0);
    rst_n = 1'b1;
    // R2 register storage
    wr(2'd1, 16'h123F); rd(2'd1, rv); chk("R2 trip pad", rv, 16'h1230);
    wr(2'd2, 16'hABCD); rd(2'd2, rv); chk("R2 release pad", rv, 16'hABC0);
    wr(2'd0, 16'h00FF); rd(2'd0, rv); chk("R2 ctl rsvd", rv, 16'h00BF);
    rd(2'd3, rv); chk("R2 addr3", rv, 16'h0000);
    // limits for the sweep: trip +1.0 (0x0100), release -1.0 (0xFF00)
    wr(2'd1, 16'h0100);
    wr(2'd2, 16'hFF00);
    // R3 R4 R5 R6 R7 sweep: mode x polarity x queue x bus-alert
    for (int md = 0; md < 2; md++)
      for (int pl = 0; pl < 2; pl++)
        for (int q = 0; q < 4; q++)
          for (int sb = 0; sb < 2; sb++) begin
            wr(2'd0, {8'h00, sb[0], 2'b00, q[1:0], pl[0], md[0], 1'b1});
            m_intr = md[0]; m_pol = pl[0]; m_smb = sb[0];
            m_need = (q == 0) ? 1 : 2 * q;
            m_run = 0; m_cmp = 0; m_lat = 0; m_arm = 1;
            chk("R11 after ctl write", alert_o, exp_pin());
            for (int i = 0; i < NP; i++)
              step(pat[i], md ? "R5 R3 R6 R7 interrupt" : "R4 R3 R6 R7 comparator");
          end
    // R11: latched alarm cleared by a control write
    wr(2'd0, 16'h0007);
    @(negedge clk); res_valid = 1'b1; res_data = 16'h0200;
    @(negedge clk); res_valid = 1'b0;
    chk("R11 latched", alert_o, 1'b1);
    wr(2'd0, 16'h0007);
    chk("R11 cleared", alert_o, 1'b0);
    // R8 periodic requests
    wr(2'd0, 16'h0000);
    begin
      int n = 0, g = 0;
      while (!conv_req && n < 4 * P) begin @(negedge clk); n++; end
      chk("R8 first pulse", conv_req, 1'b1);
      do begin @(negedge clk); g++; end while (!conv_req && g < 4 * P);
      chk("R8 period", g, P);
      @(negedge clk); chk("R8 one cycle", conv_req, 1'b0);
    end
    // R9 shutdown
    wr(2'd0, 16'h0001); @(negedge clk); pulses = 0;
    repeat (3 * P) @(negedge clk);
    chk("R9 none in shutdown", pulses, 0);
    wr(2'd0, 16'h0000); pulses = 0;
    repeat (P + 1) @(negedge clk);
    chk("R9 resumed", pulses, 1);
    // R10 single conversion
    wr(2'd0, 16'h0020); @(negedge clk); pulses = 0;
    repeat (2 * P) @(negedge clk);
    chk("R10 idle", pulses, 0);
    @(negedge clk); ptr_wr_en = 1'b1; ptr_wdata = 8'h03;
    @(negedge clk); ptr_wr_en = 1'b0;
    repeat (2 * P) @(negedge clk);
    chk("R10 other pointer", pulses, 0);
    @(negedge clk); ptr_wr_en = 1'b1; ptr_wdata = 8'h04;
    @(negedge clk); ptr_wr_en = 1'b0;
    chk("R10 next cycle", conv_req, 1'b1);
    repeat (2 * P) @(negedge clk);
    chk("R10 exactly one", pulses, 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule